// File: doc/BRIEF.md
# FIFO Threshold and Error Interrupt Unit

This block sits beside a transmit byte FIFO and a receive byte FIFO of a serial controller and turns their fill levels and push/pop strobes into interrupt requests. It compares each level against a programmable trigger level and flags a low transmit level (refill wanted) or a high receive level (drain wanted). It also reports receive data that has been left unread for too long. Pushes into a full FIFO and pops from an empty one are flagged as errors, and the block forwards only the legal strobes to the FIFOs, so a rejected access leaves the FIFO contents untouched. Five transfer events from the bus engine are latched as well.

All requests collect in a 12-bit sticky status register. Software clears bits by writing ones to them, and writing back the value just read clears every pending bit. A 12-bit enable mask selects which status bits drive the single interrupt line. A packed 32-bit FIFO status word, built directly from the two levels, is provided for polling.

The stale-receive-data detector is a three-state machine. `TR_IDLE` (receive FIFO disabled or empty) moves to `TR_COUNT` once data is present. `TR_COUNT` restarts its tick counter on each accepted receive push, returns to `TR_IDLE` when the FIFO empties or is disabled, and moves to `TR_FIRED` while raising a one-cycle request on the tick that exhausts the programmed count. `TR_FIRED` returns to `TR_COUNT` on a new accepted push, or to `TR_IDLE` when the FIFO empties or is disabled.

Top module: `fit_irq_unit`

## Requirements
- R1: `fifo_stat` is combinational from the levels: TX level in bits 6:0, TX full (level equal to DEPTH) at bit 7, TX empty (level zero) at bit 8, RX level in bits 22:16, RX full at bit 23, RX empty at bit 24; all other bits are zero.
- R2: With the TX FIFO enabled (`fifo_ctl` bit 1), status bit 0 is set at each clock edge where the TX level is less than or equal to the TX trigger level held in `fifo_ctl` bits 22:16.
- R3: With the RX FIFO enabled (`fifo_ctl` bit 0), status bit 1 is set at each clock edge where the RX level is greater than or equal to the RX trigger level held in `fifo_ctl` bits 10:4.
- R4: A pop at TX level zero sets status bit 2, a push at TX level DEPTH sets bit 3, a pop at RX level zero sets bit 4, a push at RX level DEPTH sets bit 5; such strobes are withheld from the matching `*_ok` output, while legal strobes pass through in the same cycle.
- R5: `xfer_evt` bits 0..4 (done, abort, no-ack, no-device, timeout) set status bits 7..11 respectively at the clock edge where they are high.
- R6: A clock edge with `clr_stb` high clears every status bit whose `clr_mask` bit is one; a set request in the same cycle wins; bits that are neither set nor cleared hold their value.
- R7: With the RX FIFO enabled and non-empty, status bit 6 is set on the (N+1)-th `tick` after the last accepted RX push (or after data first appears), where N is `trail_limit`.
- R8: Status bit 6 is requested only once per idle stretch; an accepted RX push (even in the same cycle as a tick) restarts the count, and an empty or disabled RX FIFO stops it.
- R9: `irq` is the OR of `status & int_en` and follows changes of `int_en` without waiting for a clock edge.
- R10: A disabled FIFO sets none of its status bits (0, 2, 3 for TX; 1, 4, 5, 6 for RX).
- R11: After reset every status bit is zero, `irq` is low and the stale-data machine is in `TR_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_ctl | input | 32 | FIFO control word: bit 0 RX enable, bit 1 TX enable, 10:4 RX trigger, 22:16 TX trigger |
| int_en | input | 12 | Per-bit interrupt enable mask |
| trail_limit | input | 4 | Stale receive data tick count N |
| tick | input | 1 | Time base strobe for the stale-data counter |
| tx_level | input | 7 | TX FIFO fill level |
| rx_level | input | 7 | RX FIFO fill level |
| tx_push | input | 1 | Push request into TX FIFO |
| tx_pop | input | 1 | Pop request from TX FIFO |
| rx_push | input | 1 | Push request into RX FIFO |
| rx_pop | input | 1 | Pop request from RX FIFO |
| xfer_evt | input | 5 | Transfer event pulses: done, abort, no-ack, no-device, timeout |
| clr_stb | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 12 | Bits to clear when `clr_stb` is high |
| tx_push_ok | output | 1 | TX push forwarded to the FIFO |
| tx_pop_ok | output | 1 | TX pop forwarded to the FIFO |
| rx_push_ok | output | 1 | RX push forwarded to the FIFO |
| rx_pop_ok | output | 1 | RX pop forwarded to the FIFO |
| status | output | 12 | Sticky status register |
| fifo_stat | output | 32 | Packed FIFO status word |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong comparison or a wrong bit position shows up in `status` one clock edge after the offending level or strobe, since every request lands in the register at the next edge; the bench sweeps every level against every trigger so an off-by-one at either end is visible. A stale-data counter that is off by one tick, fails to restart on a push, or fires twice becomes visible in bit 6 on the exact tick in question. Masking or clearing faults appear in `irq` within the same cycle and in `status` one edge after the clear strobe.

// File: rtl/fit_pkg.sv
package fit_pkg;
    localparam int STAT_W  = 12;
    localparam int LVL_W   = 7;
    localparam int CNT_W   = 4;
    localparam int EVT_W   = 5;

    // status bit positions
    localparam int ST_TX_LOW  = 0;
    localparam int ST_RX_HIGH = 1;
    localparam int ST_TX_UDR  = 2;
    localparam int ST_TX_OVR  = 3;
    localparam int ST_RX_UDR  = 4;
    localparam int ST_RX_OVR  = 5;
    localparam int ST_STALE   = 6;
    localparam int ST_EVT_LO  = 7;

    // control word fields
    localparam int CTL_RX_EN   = 0;
    localparam int CTL_TX_EN   = 1;
    localparam int CTL_RX_TRIG = 4;
    localparam int CTL_TX_TRIG = 16;

    typedef enum logic [1:0] {
        TR_IDLE  = 2'd0,
        TR_COUNT = 2'd1,
        TR_FIRED = 2'd2
    } trail_state_e;
endpackage

// File: rtl/fit_fifo_watch.sv
module fit_fifo_watch
    import fit_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0
) (
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    input  logic             push,
    input  logic             pop,
    output logic             thr_hit,
    output logic             ovr,
    output logic             udr,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             full,
    output logic             empty
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign ovr     = en && push && full;
    assign udr     = en && pop && empty;

    generate
        if (IS_RX) begin : g_high
            assign thr_hit = en && (level >= trig);
        end else begin : g_low
            assign thr_hit = en && (level <= trig);
        end
    endgenerate
endmodule

// File: rtl/fit_trail_fsm.sv
module fit_trail_fsm
    import fit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             has_data,
    input  logic             arrive,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    trail_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             active;

    assign active = en && has_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TR_IDLE: begin
                if (active) begin
                    state_d = TR_COUNT;
                    cnt_d   = '0;
                end
            end
            TR_COUNT: begin
                if (!active) begin
                    state_d = TR_IDLE;
                end else if (arrive) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == limit) state_d = TR_FIRED;
                    else                cnt_d   = cnt_q + 1'b1;
                end
            end
            TR_FIRED: begin
                if (!active) begin
                    state_d = TR_IDLE;
                end else if (arrive) begin
                    state_d = TR_COUNT;
                    cnt_d   = '0;
                end
            end
            default: state_d = TR_IDLE;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TR_COUNT: fire = active && !arrive && tick && (cnt_q == limit);
            default:  fire = 1'b0;
        endcase
    end

    // R7: a request is always followed by the reported state
    assert_fire_enters_fired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == TR_FIRED));

    // R8: no second request while the stretch is already reported
    assert_single_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TR_FIRED) |-> !fire);
endmodule

// File: rtl/fit_status_reg.sv
module fit_status_reg
    import fit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr_stb,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] clr_eff;

    assign clr_eff = clr_stb ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_vec;
    end

    // R6: cleared bits without a competing request read zero afterwards
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((status & $past(clr_mask & ~set_vec)) == '0));

    // R6: bits not cleared never drop
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_eff)) & ~status) == '0));
endmodule

// File: rtl/fit_irq_unit.sv
module fit_irq_unit
    import fit_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       fifo_ctl,
    input  logic [STAT_W-1:0] int_en,
    input  logic [CNT_W-1:0]  trail_limit,
    input  logic              tick,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_push,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic [EVT_W-1:0]  xfer_evt,
    input  logic              clr_stb,
    input  logic [STAT_W-1:0] clr_mask,
    output logic              tx_push_ok,
    output logic              tx_pop_ok,
    output logic              rx_push_ok,
    output logic              rx_pop_ok,
    output logic [STAT_W-1:0] status,
    output logic [31:0]       fifo_stat,
    output logic              irq
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic tx_en, rx_en;
    logic tx_thr, tx_ovr, tx_udr, tx_full, tx_empty;
    logic rx_thr, rx_ovr, rx_udr, rx_full, rx_empty;
    logic stale_fire;
    logic [STAT_W-1:0] set_vec;
    logic unused_ctl;

    assign tx_en = fifo_ctl[CTL_TX_EN];
    assign rx_en = fifo_ctl[CTL_RX_EN];
    assign unused_ctl = ^{fifo_ctl[31:23], fifo_ctl[15:11], fifo_ctl[3:2]};

    fit_fifo_watch #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx (
        .en(tx_en), .level(tx_level), .trig(fifo_ctl[CTL_TX_TRIG +: LVL_W]),
        .push(tx_push), .pop(tx_pop), .thr_hit(tx_thr), .ovr(tx_ovr), .udr(tx_udr),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .full(tx_full), .empty(tx_empty)
    );

    fit_fifo_watch #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx (
        .en(rx_en), .level(rx_level), .trig(fifo_ctl[CTL_RX_TRIG +: LVL_W]),
        .push(rx_push), .pop(rx_pop), .thr_hit(rx_thr), .ovr(rx_ovr), .udr(rx_udr),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .full(rx_full), .empty(rx_empty)
    );

    fit_trail_fsm u_stale (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .has_data(!rx_empty),
        .arrive(rx_push_ok), .tick(tick), .limit(trail_limit), .fire(stale_fire)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[ST_TX_LOW]  = tx_thr;
        set_vec[ST_RX_HIGH] = rx_thr;
        set_vec[ST_TX_UDR]  = tx_udr;
        set_vec[ST_TX_OVR]  = tx_ovr;
        set_vec[ST_RX_UDR]  = rx_udr;
        set_vec[ST_RX_OVR]  = rx_ovr;
        set_vec[ST_STALE]   = stale_fire;
        set_vec[ST_EVT_LO +: EVT_W] = xfer_evt;
    end

    fit_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_stb(clr_stb), .clr_mask(clr_mask), .status(status)
    );

    assign irq = |(status & int_en);

    assign fifo_stat = {7'b0, rx_empty, rx_full, rx_level,
                        7'b0, tx_empty, tx_full, tx_level};

    // R4: a push into a full enabled TX FIFO is always reported
    assert_tx_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_en && tx_level == FULL_LVL) |=> status[ST_TX_OVR]);

    // R4: a pop from an empty enabled RX FIFO is always reported
    assert_rx_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_en && rx_level == '0) |=> status[ST_RX_UDR]);

    // R10: a disabled RX FIFO raises none of its bits
    assert_rx_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !$past(status[ST_STALE]) && !(clr_stb && 1'b0)) |=> !status[ST_STALE] || $past(status[ST_STALE]));
endmodule

// File: tb/tb_fit_irq_unit.sv
module tb_fit_irq_unit;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fifo_ctl = '0;
    logic [11:0] int_en = '0;
    logic [3:0]  trail_limit = '0;
    logic        tick = 1'b0;
    logic [6:0]  tx_level = '0, rx_level = '0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [4:0]  xfer_evt = '0;
    logic        clr_stb = 1'b0;
    logic [11:0] clr_mask = '0;
    logic        tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok, irq;
    logic [11:0] status;
    logic [31:0] fifo_stat;

    int n_chk = 0;
    int n_fail = 0;

    fit_irq_unit #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_ctl(fifo_ctl), .int_en(int_en),
        .trail_limit(trail_limit), .tick(tick), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .xfer_evt(xfer_evt), .clr_stb(clr_stb), .clr_mask(clr_mask),
        .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok), .rx_push_ok(rx_push_ok),
        .rx_pop_ok(rx_pop_ok), .status(status), .fifo_stat(fifo_stat), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // caller sits at a negedge with inputs set; one edge loads requests over a full clear
    task automatic apply_clear();
        clr_stb = 1'b1;
        clr_mask = 12'hFFF;
        @(negedge clk);
        clr_stb = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int_en = 12'hFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 status", {20'b0, status}, 32'h0);
        check("R11 irq", {31'b0, irq}, 32'h0);
        int_en = '0;

        // R1 packed status word, every level pair
        for (int t = 0; t <= D; t++) begin
            for (int r = 0; r <= D; r++) begin
                tx_level = 7'(t);
                rx_level = 7'(r);
                #1;
                check("R1 fifo_stat", fifo_stat,
                      32'(t) | (32'(t == D) << 7) | (32'(t == 0) << 8) |
                      (32'(r) << 16) | (32'(r == D) << 23) | (32'(r == 0) << 24));
            end
        end
        @(negedge clk);

        // R2 / R3 threshold sweep
        for (int g = 0; g <= D; g++) begin
            for (int l = 0; l <= D; l++) begin
                fifo_ctl = 32'h3 | (32'(g) << 4) | (32'(g) << 16);
                tx_level = 7'(l);
                rx_level = 7'(l);
                apply_clear();
                check("R2 tx low", {31'b0, status[0]}, 32'(l <= g));
                check("R3 rx high", {31'b0, status[1]}, 32'(l >= g));
            end
        end

        // R4 overrun / underrun with strobe gating
        fifo_ctl = 32'h3 | (32'd8 << 4);
        tx_level = 7'(D); rx_level = 7'd3; tx_push = 1'b1;
        #1 check("R4 tx push refused", {31'b0, tx_push_ok}, 32'h0);
        apply_clear(); tx_push = 1'b0;
        check("R4 tx overrun", {31'b0, status[3]}, 32'h1);
        tx_level = 7'd3; tx_push = 1'b1;
        #1 check("R4 tx push passes", {31'b0, tx_push_ok}, 32'h1);
        apply_clear(); tx_push = 1'b0;
        check("R4 tx no overrun", {31'b0, status[3]}, 32'h0);
        tx_level = 7'd0; tx_pop = 1'b1;
        #1 check("R4 tx pop refused", {31'b0, tx_pop_ok}, 32'h0);
        apply_clear(); tx_pop = 1'b0;
        check("R4 tx underrun", {31'b0, status[2]}, 32'h1);
        rx_level = 7'(D); rx_push = 1'b1;
        #1 check("R4 rx push refused", {31'b0, rx_push_ok}, 32'h0);
        apply_clear(); rx_push = 1'b0;
        check("R4 rx overrun", {31'b0, status[5]}, 32'h1);
        rx_level = 7'd0; rx_pop = 1'b1;
        #1 check("R4 rx pop refused", {31'b0, rx_pop_ok}, 32'h0);
        apply_clear(); rx_pop = 1'b0;
        check("R4 rx underrun", {31'b0, status[4]}, 32'h1);
        rx_level = 7'd4; rx_pop = 1'b1;
        #1 check("R4 rx pop passes", {31'b0, rx_pop_ok}, 32'h1);
        apply_clear(); rx_pop = 1'b0;
        check("R4 rx no underrun", {31'b0, status[4]}, 32'h0);

        // R10 disabled FIFOs raise nothing
        fifo_ctl = (32'd5 << 16) | (32'd0 << 4);
        tx_level = 7'(D); rx_level = 7'd0;
        tx_push = 1'b1; rx_pop = 1'b1;
        apply_clear();
        tx_level = 7'd0; tx_push = 1'b0; tx_pop = 1'b1; rx_pop = 1'b0;
        rx_level = 7'(D); rx_push = 1'b1; trail_limit = 4'd0; tick = 1'b1;
        apply_clear();
        tx_pop = 1'b0; rx_push = 1'b0; tick = 1'b0;
        check("R10 disabled bits", {20'b0, status}, 32'h0);
        pulse_tick(); pulse_tick();
        check("R10 disabled stale", {20'b0, status}, 32'h0);

        // R5 event sweep
        fifo_ctl = '0;
        for (int e = 0; e < 32; e++) begin
            xfer_evt = 5'(e);
            apply_clear();
            xfer_evt = '0;
            check("R5 events", {20'b0, status}, 32'(e) << 7);
        end

        // R6 partial clear, hold, set-wins
        xfer_evt = 5'h1F;
        @(negedge clk);
        xfer_evt = '0;
        clr_stb = 1'b1; clr_mask = 12'h100;
        @(negedge clk);
        clr_stb = 1'b0;
        check("R6 partial clear", {20'b0, status}, 32'hE80);
        @(negedge clk);
        check("R6 hold", {20'b0, status}, 32'hE80);
        xfer_evt = 5'h02; clr_stb = 1'b1; clr_mask = 12'h100;
        @(negedge clk);
        clr_stb = 1'b0; xfer_evt = '0;
        check("R6 set wins", {20'b0, status}, 32'hF80);
        clr_stb = 1'b1; clr_mask = 12'h100;
        @(negedge clk);
        clr_stb = 1'b0;

        // R9 interrupt mask, combinational
        int_en = 12'h000;
        #1 check("R9 irq none", {31'b0, irq}, 32'h0);
        int_en = 12'h100;
        #1 check("R9 irq cleared bit", {31'b0, irq}, 32'h0);
        int_en = 12'h800;
        #1 check("R9 irq timeout bit", {31'b0, irq}, 32'h1);
        int_en = 12'h000;
        #1 check("R9 irq silenced", {31'b0, irq}, 32'h0);
        @(negedge clk);

        // R7 / R8 stale receive data
        fifo_ctl = 32'h1 | (32'd8 << 4);
        rx_level = 7'd2; tx_level = 7'd3; trail_limit = 4'd3;
        @(negedge clk);
        apply_clear();
        for (int k = 1; k <= 4; k++) begin
            pulse_tick();
            check("R7 stale count", {31'b0, status[6]}, 32'(k == 4));
        end
        apply_clear();
        for (int k = 1; k <= 5; k++) begin
            pulse_tick();
            check("R8 no refire", {31'b0, status[6]}, 32'h0);
        end
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            pulse_tick();
            check("R8 push restarts", {31'b0, status[6]}, 32'(k == 4));
        end
        apply_clear();
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        pulse_tick(); pulse_tick();
        rx_push = 1'b1; tick = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; tick = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            pulse_tick();
            check("R8 push with tick restarts", {31'b0, status[6]}, 32'(k == 4));
        end
        rx_level = 7'd0;
        @(negedge clk);
        apply_clear();
        for (int k = 1; k <= 6; k++) begin
            pulse_tick();
            check("R8 empty stops", {31'b0, status[6]}, 32'h0);
        end
        trail_limit = 4'd0; rx_level = 7'd1;
        @(negedge clk);
        pulse_tick();
        check("R7 limit zero", {31'b0, status[6]}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule